// File: doc/BRIEF.md
# Paged Data Address Generator

This block forms the data addresses for a DSP core. Eight 16-bit index registers act as pointers, and eight modify registers hold their step values. Two 8-bit page registers extend each pointer to a 24-bit address. The lower half of the index bank (selects 0–3) takes its upper address byte from page A. The upper half (selects 4–7) takes it from page B.

Each cycle the core presents one operation, an index select, a modify select and an 8-bit immediate. The block registers the resulting 24-bit address and raises a one-cycle valid strobe whenever the operation reads or writes memory. The supported forms are:

- post-modify with write-back;
- pre-modify with no write-back;
- either of these with a signed immediate in place of a modify register;
- a pointer step that makes no memory access.

A separate write port loads index, modify and page registers. Pointer arithmetic is always linear and wraps within 16 bits.

Top module: `pag_dag_top`

## Requirements
- R1: After reset, `addr_o` is 0, `addr_vld_o` is 0, and every index, modify and page register is 0.
- R2: Post-modify with a register (`op_i`=1) puts the current index on `addr_o[15:0]`. It then sets the index to index plus the selected modify register, modulo 2^16.
- R3: Pre-modify with a register (`op_i`=3) puts index plus the modify register on `addr_o[15:0]` and leaves the index unchanged.
- R4: The immediate forms, post (`op_i`=2) and pre (`op_i`=4), behave as in R2 and R3 with `imm_i` as an 8-bit two's-complement value sign-extended to 16 bits in place of the modify register. For example, 0xFC subtracts 4.
- R5: Modify-only (`op_i`=5) adds the sign-extended `imm_i` to the selected index. It holds `addr_vld_o` at 0 and leaves `addr_o` unchanged.
- R6: For a memory operation, `addr_o[23:16]` is page A when `isel_i[2]` is 0 and page B when `isel_i[2]` is 1.
- R7: A carry or borrow out of bit 15 of the index is discarded and never alters a page register.
- R8: A write with `wr_kind_i`=2 loads `wr_data_i[7:0]` into page A (`wr_sel_i[0]`=0) or page B (`wr_sel_i[0]`=1). An operation in the same cycle still uses the old page, and later operations use the new one.
- R9: Writes with `wr_kind_i`=0 (index) and `wr_kind_i`=1 (modify) load `wr_data_i` into register `wr_sel_i`. An operation in the same cycle reads the old values. If the operation would also update the same index, the port write wins.
- R10: The address and strobe are registered. `addr_vld_o` is 1 for exactly the cycle after each memory operation (`op_i` 1–4). It is 0 after a no-op (`op_i` 0, 6 or 7), and a no-op changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code |
| isel_i | input | 3 | Index register select |
| msel_i | input | 3 | Modify register select |
| imm_i | input | 8 | Signed immediate |
| wr_en_i | input | 1 | Register write enable |
| wr_kind_i | input | 2 | Write target: 0 index, 1 modify, 2 page |
| wr_sel_i | input | 3 | Write register select |
| wr_data_i | input | 16 | Write data |
| addr_o | output | 24 | Registered address |
| addr_vld_o | output | 1 | Address valid strobe |

## Verification
The write-back assertions assume the core never drives an operation code of 6 or 7 expecting an effect. They also assume that any port write to the index an operation updates is deliberate, so those checks are qualified by the absence of a colliding write. The stimulus drives every input on the falling edge and returns to a no-op between scenarios. Collisions occur only in the scenario built to exercise them. Index values are observed through pre-modify probes with a zero immediate, which change nothing.

// File: rtl/pag_pkg.sv
package pag_pkg;
  localparam int unsigned IDX_W  = 16;
  localparam int unsigned PAGE_W = 8;
  localparam int unsigned IMM_W  = 8;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_POST_M = 3'd1,
    OP_POST_I = 3'd2,
    OP_PRE_M  = 3'd3,
    OP_PRE_I  = 3'd4,
    OP_STEP_I = 3'd5
  } pag_op_e;

  typedef enum logic [1:0] {
    WK_INDEX  = 2'd0,
    WK_MODIFY = 2'd1,
    WK_PAGE   = 2'd2
  } pag_wkind_e;

  function automatic logic op_is_mem(input logic [2:0] op);
    return (op == OP_POST_M) || (op == OP_POST_I) || (op == OP_PRE_M) || (op == OP_PRE_I);
  endfunction

  function automatic logic op_is_post(input logic [2:0] op);
    return (op == OP_POST_M) || (op == OP_POST_I);
  endfunction

  function automatic logic op_uses_imm(input logic [2:0] op);
    return (op == OP_POST_I) || (op == OP_PRE_I) || (op == OP_STEP_I);
  endfunction

  function automatic logic op_writes_back(input logic [2:0] op);
    return op_is_post(op) || (op == OP_STEP_I);
  endfunction
endpackage

// File: rtl/pag_regbank.sv
module pag_regbank #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 16,
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SW-1:0]     wsel,
  input  logic [W-1:0]      wdata,
  input  logic              upd_en,
  input  logic [SW-1:0]     upd_sel,
  input  logic [W-1:0]      upd_data,
  output logic [N-1:0][W-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [W-1:0] nxt;
    logic         en;

    always_comb begin
      nxt = q[g];
      en  = 1'b0;
      if (we && (wsel == SW'(g))) begin
        nxt = wdata;
        en  = 1'b1;
      end else if (upd_en && (upd_sel == SW'(g))) begin
        nxt = upd_data;
        en  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[g] <= '0;
      end else if (en) begin
        q[g] <= nxt;
      end
    end
  end
endmodule

// File: rtl/pag_addr_unit.sv
module pag_addr_unit
  import pag_pkg::*;
#(
  parameter int unsigned IW = IDX_W,
  parameter int unsigned PW = PAGE_W,
  parameter int unsigned MW = IMM_W
) (
  input  logic [2:0]     op,
  input  logic [IW-1:0]  idx_val,
  input  logic [IW-1:0]  mod_val,
  input  logic [MW-1:0]  imm,
  input  logic [PW-1:0]  page_val,
  output logic [PW+IW-1:0] eff_addr,
  output logic           mem_acc,
  output logic           idx_upd,
  output logic [IW-1:0]  idx_new
);
  logic [IW-1:0] imm_ext;
  logic [IW-1:0] offset;
  logic [IW-1:0] sum;

  always_comb begin
    imm_ext  = {{(IW-MW){imm[MW-1]}}, imm};
    offset   = op_uses_imm(op) ? imm_ext : mod_val;
    sum      = idx_val + offset;
    mem_acc  = op_is_mem(op);
    idx_upd  = op_writes_back(op);
    idx_new  = sum;
    eff_addr = {page_val, (op_is_post(op) ? idx_val : sum)};
  end
endmodule

// File: rtl/pag_out_reg.sv
module pag_out_reg #(
  parameter int unsigned AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] addr_d,
  output logic [AW-1:0] addr_q,
  output logic          vld_q
);
  logic [AW-1:0] addr_nxt;

  always_comb begin
    addr_nxt = ld ? addr_d : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      addr_q <= addr_nxt;
      vld_q  <= ld;
    end
  end
endmodule

// File: rtl/pag_dag_top.sv
module pag_dag_top
  import pag_pkg::*;
#(
  parameter int unsigned N_IDX   = 8,
  parameter int unsigned N_PAGE  = 2,
  localparam int unsigned ISW    = $clog2(N_IDX),
  localparam int unsigned PSW    = (N_PAGE > 1) ? $clog2(N_PAGE) : 1,
  localparam int unsigned AW     = PAGE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [ISW-1:0]    isel_i,
  input  logic [ISW-1:0]    msel_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_kind_i,
  input  logic [ISW-1:0]    wr_sel_i,
  input  logic [IDX_W-1:0]  wr_data_i,
  output logic [AW-1:0]     addr_o,
  output logic              addr_vld_o
);
  logic [N_IDX-1:0][IDX_W-1:0]   idx_q;
  logic [N_IDX-1:0][IDX_W-1:0]   mod_q;
  logic [N_PAGE-1:0][PAGE_W-1:0] page_q;

  logic              wr_idx, wr_mod, wr_pg;
  logic [PSW-1:0]    pg_of_isel;
  logic [IDX_W-1:0]  idx_cur, mod_cur;
  logic [PAGE_W-1:0] page_cur;
  logic [AW-1:0]     eff_addr;
  logic              mem_acc, idx_upd;
  logic [IDX_W-1:0]  idx_new;

  always_comb begin
    wr_idx     = wr_en_i && (wr_kind_i == WK_INDEX);
    wr_mod     = wr_en_i && (wr_kind_i == WK_MODIFY);
    wr_pg      = wr_en_i && (wr_kind_i == WK_PAGE);
    pg_of_isel = isel_i[ISW-1 -: PSW];
    idx_cur    = idx_q[isel_i];
    mod_cur    = mod_q[msel_i];
    page_cur   = page_q[pg_of_isel];
  end

  pag_regbank #(.N(N_IDX), .W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n),
    .we(wr_idx), .wsel(wr_sel_i), .wdata(wr_data_i),
    .upd_en(idx_upd), .upd_sel(isel_i), .upd_data(idx_new),
    .q(idx_q)
  );

  pag_regbank #(.N(N_IDX), .W(IDX_W)) u_mod (
    .clk(clk), .rst_n(rst_n),
    .we(wr_mod), .wsel(wr_sel_i), .wdata(wr_data_i),
    .upd_en(1'b0), .upd_sel('0), .upd_data('0),
    .q(mod_q)
  );

  pag_regbank #(.N(N_PAGE), .W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n),
    .we(wr_pg), .wsel(wr_sel_i[PSW-1:0]), .wdata(wr_data_i[PAGE_W-1:0]),
    .upd_en(1'b0), .upd_sel('0), .upd_data('0),
    .q(page_q)
  );

  pag_addr_unit #(.IW(IDX_W), .PW(PAGE_W), .MW(IMM_W)) u_au (
    .op(op_i), .idx_val(idx_cur), .mod_val(mod_cur), .imm(imm_i),
    .page_val(page_cur), .eff_addr(eff_addr), .mem_acc(mem_acc),
    .idx_upd(idx_upd), .idx_new(idx_new)
  );

  pag_out_reg #(.AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n), .ld(mem_acc), .addr_d(eff_addr),
    .addr_q(addr_o), .vld_q(addr_vld_o)
  );

  logic idx_hit;
  always_comb idx_hit = wr_idx && (wr_sel_i == isel_i);

  assert_vld_after_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_is_mem(op_i) |=> addr_vld_o);

  assert_no_vld_on_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !op_is_mem(op_i) |=> (!addr_vld_o && $stable(addr_o)));

  assert_pre_keeps_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == OP_PRE_M || op_i == OP_PRE_I) && !idx_hit)
      |=> idx_q[$past(isel_i)] == $past(idx_cur));

  assert_post_reg_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_POST_M && !idx_hit)
      |=> idx_q[$past(isel_i)] == IDX_W'($past(idx_cur) + $past(mod_cur)));

  assert_page_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_is_mem(op_i) |=> addr_o[AW-1 -: PAGE_W] == $past(page_cur));

  assert_page_only_by_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pg |=> $stable(page_q));

  assert_port_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx |=> idx_q[$past(wr_sel_i)] == $past(wr_data_i));
endmodule

// File: tb/sim_pag_dag_top.sv
`timescale 1ns/1ps
module sim_pag_dag_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_i;
  logic [2:0]  isel_i, msel_i;
  logic [7:0]  imm_i;
  logic        wr_en_i;
  logic [1:0]  wr_kind_i;
  logic [2:0]  wr_sel_i;
  logic [15:0] wr_data_i;
  logic [23:0] addr_o;
  logic        addr_vld_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_idx [8];
  logic [15:0] m_mod [8];
  logic [7:0]  m_pg  [2];

  always #2.5 clk = ~clk;

  pag_dag_top u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .isel_i(isel_i), .msel_i(msel_i),
    .imm_i(imm_i), .wr_en_i(wr_en_i), .wr_kind_i(wr_kind_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .addr_o(addr_o), .addr_vld_o(addr_vld_o)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sx(input logic [7:0] v);
    return {{8{v[7]}}, v};
  endfunction

  task automatic idle();
    op_i = 3'd0; isel_i = 0; msel_i = 0; imm_i = 0;
    wr_en_i = 0; wr_kind_i = 0; wr_sel_i = 0; wr_data_i = 0;
  endtask

  task automatic wr(input logic [1:0] k, input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    idle();
    wr_en_i = 1; wr_kind_i = k; wr_sel_i = s; wr_data_i = d;
    @(negedge clk);
    idle();
    if (k == 0) m_idx[s] = d;
    else if (k == 1) m_mod[s] = d;
    else if (k == 2) m_pg[s[0]] = d[7:0];
  endtask

  // Runs one operation and compares against the model; returns nothing
  task automatic run(input string req, input logic [2:0] op, input logic [2:0] is,
                     input logic [2:0] ms, input logic [7:0] im);
    logic [15:0] base, off, sum;
    logic [23:0] exp_a, prev_a;
    logic        mem;
    @(negedge clk);
    idle();
    op_i = op; isel_i = is; msel_i = ms; imm_i = im;
    prev_a = addr_o;
    base = m_idx[is];
    off  = (op == 2 || op == 4 || op == 5) ? sx(im) : m_mod[ms];
    sum  = base + off;
    mem  = (op >= 1 && op <= 4);
    exp_a = mem ? {m_pg[is[2]], ((op == 1 || op == 2) ? base : sum)} : prev_a;
    @(negedge clk);
    idle();
    chk(req, addr_o, exp_a);
    chk(req, {23'd0, addr_vld_o}, {23'd0, mem});
    if (op == 1 || op == 2 || op == 5) m_idx[is] = sum;
  endtask

  task automatic probe(input string req, input logic [2:0] is);
    run(req, 3'd4, is, 3'd0, 8'h00);
  endtask

  task automatic t_reset();
    chk("R1 addr", addr_o, 24'h0);
    chk("R1 vld", {23'd0, addr_vld_o}, 24'h0);
    probe("R1 idx5", 3'd5);
    run("R1 mod", 3'd3, 3'd0, 3'd6, 8'h00);
  endtask

  task automatic t_post_reg();
    wr(0, 3'd1, 16'h1000);
    wr(1, 3'd2, 16'h0010);
    run("R2 post", 3'd1, 3'd1, 3'd2, 8'h00);
    run("R2 post again", 3'd1, 3'd1, 3'd2, 8'h00);
    probe("R2 idx", 3'd1);
  endtask

  task automatic t_pre_reg();
    wr(0, 3'd3, 16'h2000);
    wr(1, 3'd4, 16'h0100);
    run("R3 pre", 3'd3, 3'd3, 3'd4, 8'h00);
    probe("R3 unchanged", 3'd3);
  endtask

  task automatic t_imm();
    wr(0, 3'd0, 16'h0050);
    run("R4 post imm -4", 3'd2, 3'd0, 3'd0, 8'hFC);
    probe("R4 after -4", 3'd0);
    run("R4 pre imm +127", 3'd4, 3'd0, 3'd0, 8'h7F);
    run("R4 pre imm -128", 3'd4, 3'd0, 3'd0, 8'h80);
    probe("R4 pre no wb", 3'd0);
  endtask

  task automatic t_step();
    run("R5 seed addr", 3'd4, 3'd2, 3'd0, 8'h00);
    run("R5 step +24", 3'd5, 3'd6, 3'd0, 8'd24);
    run("R5 step -1", 3'd5, 3'd6, 3'd0, 8'hFF);
    probe("R5 idx6", 3'd6);
  endtask

  task automatic t_pages();
    wr(2, 3'd0, 16'hFF12);
    wr(2, 3'd1, 16'h0034);
    for (int i = 0; i < 8; i++) probe("R6 page by bank", 3'(i));
  endtask

  task automatic t_wrap();
    wr(0, 3'd7, 16'hFFFE);
    run("R7 post +4 wrap", 3'd2, 3'd7, 3'd0, 8'h04);
    probe("R7 wrapped idx", 3'd7);
    run("R7 step -8 wrap", 3'd5, 3'd7, 3'd0, 8'hF8);
    probe("R7 page intact", 3'd7);
  endtask

  task automatic t_page_timing();
    @(negedge clk);
    idle();
    wr_en_i = 1; wr_kind_i = 2; wr_sel_i = 3'd0; wr_data_i = 16'h00A5;
    op_i = 3'd4; isel_i = 3'd1; imm_i = 8'h00;
    @(negedge clk);
    idle();
    chk("R8 same-cycle old page", addr_o, {m_pg[0], m_idx[1]});
    m_pg[0] = 8'hA5;
    probe("R8 new page", 3'd1);
    probe("R8 other page kept", 3'd4);
  endtask

  task automatic t_priority();
    wr(1, 3'd5, 16'h0003);
    @(negedge clk);
    idle();
    wr_en_i = 1; wr_kind_i = 0; wr_sel_i = 3'd2; wr_data_i = 16'h4444;
    op_i = 3'd1; isel_i = 3'd2; msel_i = 3'd5;
    @(negedge clk);
    idle();
    chk("R9 old index used", addr_o, {m_pg[0], m_idx[2]});
    m_idx[2] = 16'h4444;
    probe("R9 port write wins", 3'd2);
    @(negedge clk);
    idle();
    wr_en_i = 1; wr_kind_i = 1; wr_sel_i = 3'd5; wr_data_i = 16'h0100;
    op_i = 3'd3; isel_i = 3'd2; msel_i = 3'd5;
    @(negedge clk);
    idle();
    chk("R9 old modify used", addr_o, {m_pg[0], 16'h4447});
    m_mod[5] = 16'h0100;
    run("R9 new modify", 3'd3, 3'd2, 3'd5, 8'h00);
  endtask

  task automatic t_nop();
    logic [23:0] a;
    probe("R10 setup", 3'd0);
    a = addr_o;
    run("R10 nop 0", 3'd0, 3'd0, 3'd2, 8'h10);
    run("R10 op 6", 3'd6, 3'd0, 3'd2, 8'h10);
    run("R10 op 7", 3'd7, 3'd0, 3'd2, 8'h10);
    chk("R10 addr held", addr_o, a);
    probe("R10 idx untouched", 3'd0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_idx[i] = 0; m_mod[i] = 0; end
    m_pg[0] = 0; m_pg[1] = 0;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_post_reg();
    t_pre_reg();
    t_imm();
    t_step();
    t_pages();
    t_wrap();
    t_page_timing();
    t_priority();
    t_nop();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule